// File: doc/BRIEF.md
# Instruction cycle cost estimator

This block estimates how many execution clocks a decoded data-move or add instruction would need. Each instruction arrives as a classification of its operands rather than as an encoding: an operation code, whether the destination is a register or memory, whether the source is a register, an immediate or memory, a flag on each side marking the accumulator register, and the effective-address cost already worked out upstream. From these the block picks a base cost from a prioritised table of operand forms, adds the effective-address cost where the form touches memory, and reports the result one cycle later.

Every accepted, supported instruction also adds its cost to a 32-bit running total that a clear input resets. Forms the table does not cover are flagged as unsupported, report a cost of zero and leave the total alone. A two-state machine marks the reporting cycles. ST_IDLE means no result is on the outputs, and ST_REPORT means a result is being presented. The transitions are T_ACCEPT (ST_IDLE to ST_REPORT when an instruction is offered), T_STREAM (ST_REPORT to ST_REPORT on back-to-back instructions), T_DRAIN (ST_REPORT to ST_IDLE when none is offered) and T_WAIT (ST_IDLE to ST_IDLE).

Top module: `cce_top`

## Requirements
- R1: For a move (in_op = 0), an accumulator-to-memory form (source kind register with in_src_acc = 1 and in_dst_mem = 1) or a memory-to-accumulator form (in_dst_mem = 0 with in_dst_acc = 1 and source kind memory) costs 10. This form wins over every other move form, and no effective-address cost is added.
- R2: A move from register to register (source kind 0, in_dst_mem = 0) costs 2. A move of an immediate (source kind 1) into a register costs 4.
- R3: Each move that involves memory and is not covered by R1 costs a base plus in_ea_cost. The base is 8 from memory (source kind 2) into a register, 9 from a register into memory, and 10 for an immediate into memory.
- R4: An add (in_op = 1) costs 3 from register to register and 4 for an immediate into any register. On adds the accumulator flags have no effect.
- R5: Each add that involves memory costs a base plus in_ea_cost. The base is 9 from memory into a register, 16 from a register into memory, and 17 for an immediate into memory.
- R6: The following forms are unsupported: in_op of 2 or 3, source kind 3, and a memory source with a memory destination. Each of them sets res_unsup, reports res_cost = 0 and leaves total unchanged.
- R7: A result appears on res_valid, res_cost and res_unsup on the clock edge after the one that samples in_valid = 1. In cycles that follow no offered instruction, res_valid is 0.
- R8: Each supported instruction adds its res_cost to total, and the new total is visible together with the result.
- R9: A clear zeroes total on the next edge. Clear takes priority over an instruction offered in the same cycle: that instruction's cost is still reported on res_cost but is not added.
- R10: After reset, res_valid, res_cost, res_unsup and total are all 0.
- R11: in_ea_cost has no effect on register-only forms, immediate-to-register forms or the accumulator form of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_op | input | 2 | 0 move, 1 add, 2 and 3 unsupported |
| in_dst_mem | input | 1 | 1 if the destination is memory, 0 if it is a register |
| in_dst_acc | input | 1 | Destination register is the accumulator |
| in_src_kind | input | 2 | 0 register, 1 immediate, 2 memory, 3 unsupported |
| in_src_acc | input | 1 | Source register is the accumulator |
| in_ea_cost | input | EA_W (5) | Effective-address cost of the memory operand |
| clear | input | 1 | Zero the running total |
| res_valid | output | 1 | Result outputs are valid |
| res_cost | output | COST_W (8) | Estimated clocks of the instruction |
| res_unsup | output | 1 | Instruction form is not covered |
| total | output | TOT_W (32) | Running sum of supported costs |

## Verification
The bench targets the accumulator-to-memory move with a nonzero effective-address cost. A table that checks that case too late would return 9 or 8 plus the address cost rather than 10. Adds with the accumulator flag set cover a design that wrongly reuses the move accumulator case for adds. A large address cost applied to register and immediate forms exposes a design that adds the penalty unconditionally. Memory-to-memory and reserved codes must leave the total untouched, and a clear issued together with an instruction must still leave the total at zero; a design that gives the addition priority over the clear would leave the cost in the total.

// File: rtl/cce_pkg.sv
package cce_pkg;

    typedef enum logic [1:0] {
        OP_MOVE  = 2'd0,
        OP_ADD   = 2'd1,
        OP_RSV_A = 2'd2,
        OP_RSV_B = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    // Operand form after prioritised classification.
    typedef enum logic [3:0] {
        FORM_NONE,
        FORM_MOV_ACC_MEM,
        FORM_MOV_REG_REG,
        FORM_MOV_IMM_REG,
        FORM_MOV_MEM_REG,
        FORM_MOV_REG_MEM,
        FORM_MOV_IMM_MEM,
        FORM_ADD_REG_REG,
        FORM_ADD_IMM_REG,
        FORM_ADD_MEM_REG,
        FORM_ADD_REG_MEM,
        FORM_ADD_IMM_MEM
    } form_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } state_e;

    localparam int unsigned BASE_W = 5;

    typedef struct packed {
        form_e form;
        logic  unsup;
    } class_t;

    function automatic logic [BASE_W-1:0] form_base(input form_e f);
        logic [BASE_W-1:0] b;
        unique case (f)
            FORM_MOV_ACC_MEM: b = 5'd10;
            FORM_MOV_REG_REG: b = 5'd2;
            FORM_MOV_IMM_REG: b = 5'd4;
            FORM_MOV_MEM_REG: b = 5'd8;
            FORM_MOV_REG_MEM: b = 5'd9;
            FORM_MOV_IMM_MEM: b = 5'd10;
            FORM_ADD_REG_REG: b = 5'd3;
            FORM_ADD_IMM_REG: b = 5'd4;
            FORM_ADD_MEM_REG: b = 5'd9;
            FORM_ADD_REG_MEM: b = 5'd16;
            FORM_ADD_IMM_MEM: b = 5'd17;
            default:          b = 5'd0;
        endcase
        return b;
    endfunction

    function automatic logic form_uses_ea(input form_e f);
        logic u;
        unique case (f)
            FORM_MOV_MEM_REG,
            FORM_MOV_REG_MEM,
            FORM_MOV_IMM_MEM,
            FORM_ADD_MEM_REG,
            FORM_ADD_REG_MEM,
            FORM_ADD_IMM_MEM: u = 1'b1;
            default:          u = 1'b0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/cce_form_decode.sv
module cce_form_decode
    import cce_pkg::*;
(
    input  logic [1:0] op,
    input  logic       dst_mem,
    input  logic       dst_acc,
    input  logic [1:0] src_kind,
    input  logic       src_acc,
    output class_t     cls
);

    op_e  op_q;
    src_e src_q;
    logic acc_mem_move;

    assign op_q  = op_e'(op);
    assign src_q = src_e'(src_kind);

    // Accumulator exchange with memory, either direction.
    assign acc_mem_move = (src_q == SRC_REG && src_acc && dst_mem) ||
                          (src_q == SRC_MEM && dst_acc && !dst_mem);

    always_comb begin
        cls.form  = FORM_NONE;
        cls.unsup = 1'b0;
        if (src_q == SRC_RSV || (dst_mem && src_q == SRC_MEM)) begin
            cls.unsup = 1'b1;
        end else begin
            unique case (op_q)
                OP_MOVE: begin
                    if (acc_mem_move) begin
                        cls.form = FORM_MOV_ACC_MEM;
                    end else begin
                        unique case ({dst_mem, src_q})
                            {1'b0, SRC_REG}: cls.form = FORM_MOV_REG_REG;
                            {1'b0, SRC_IMM}: cls.form = FORM_MOV_IMM_REG;
                            {1'b0, SRC_MEM}: cls.form = FORM_MOV_MEM_REG;
                            {1'b1, SRC_REG}: cls.form = FORM_MOV_REG_MEM;
                            {1'b1, SRC_IMM}: cls.form = FORM_MOV_IMM_MEM;
                            default:         cls.unsup = 1'b1;
                        endcase
                    end
                end
                OP_ADD: begin
                    unique case ({dst_mem, src_q})
                        {1'b0, SRC_REG}: cls.form = FORM_ADD_REG_REG;
                        {1'b0, SRC_IMM}: cls.form = FORM_ADD_IMM_REG;
                        {1'b0, SRC_MEM}: cls.form = FORM_ADD_MEM_REG;
                        {1'b1, SRC_REG}: cls.form = FORM_ADD_REG_MEM;
                        {1'b1, SRC_IMM}: cls.form = FORM_ADD_IMM_MEM;
                        default:         cls.unsup = 1'b1;
                    endcase
                end
                OP_RSV_A,
                OP_RSV_B: cls.unsup = 1'b1;
                default:  cls.unsup = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/cce_cost_calc.sv
module cce_cost_calc
    import cce_pkg::*;
#(
    parameter int unsigned EA_W   = 5,
    parameter int unsigned COST_W = 8
) (
    input  class_t            cls,
    input  logic [EA_W-1:0]   ea_cost,
    output logic [COST_W-1:0] cost
);

    logic [COST_W-1:0] base_ext;
    logic [COST_W-1:0] ea_ext;

    assign base_ext = COST_W'(form_base(cls.form));
    assign ea_ext   = form_uses_ea(cls.form) ? COST_W'(ea_cost) : '0;

    always_comb begin
        if (cls.unsup) begin
            cost = '0;
        end else begin
            cost = base_ext + ea_ext;
        end
    end

endmodule

// File: rtl/cce_total_acc.sv
module cce_total_acc #(
    parameter int unsigned COST_W = 8,
    parameter int unsigned TOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [COST_W-1:0] add_val,
    output logic [TOT_W-1:0]  total
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clear) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + TOT_W'(add_val);
        end
    end

endmodule

// File: rtl/cce_top.sv
module cce_top
    import cce_pkg::*;
#(
    parameter int unsigned EA_W   = 5,
    parameter int unsigned COST_W = 8,
    parameter int unsigned TOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_dst_mem,
    input  logic              in_dst_acc,
    input  logic [1:0]        in_src_kind,
    input  logic              in_src_acc,
    input  logic [EA_W-1:0]   in_ea_cost,
    input  logic              clear,
    output logic              res_valid,
    output logic [COST_W-1:0] res_cost,
    output logic              res_unsup,
    output logic [TOT_W-1:0]  total
);

    class_t            cls;
    logic [COST_W-1:0] cost_now;
    logic              add_en;
    state_e            state_q;
    state_e            state_d;

    cce_form_decode u_decode (
        .op       (in_op),
        .dst_mem  (in_dst_mem),
        .dst_acc  (in_dst_acc),
        .src_kind (in_src_kind),
        .src_acc  (in_src_acc),
        .cls      (cls)
    );

    cce_cost_calc #(
        .EA_W   (EA_W),
        .COST_W (COST_W)
    ) u_cost (
        .cls     (cls),
        .ea_cost (in_ea_cost),
        .cost    (cost_now)
    );

    assign add_en = in_valid && !cls.unsup;

    cce_total_acc #(
        .COST_W (COST_W),
        .TOT_W  (TOT_W)
    ) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .add_en  (add_en),
        .add_val (cost_now),
        .total   (total)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;   // T_ACCEPT / T_WAIT
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;   // T_STREAM / T_DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers, loaded on each accepted instruction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_cost  <= '0;
            res_unsup <= 1'b0;
        end else if (in_valid) begin
            res_cost  <= cost_now;
            res_unsup <= cls.unsup;
        end
    end

    assign res_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/cce_checker.sv
module cce_checker #(
    parameter int unsigned EA_W   = 5,
    parameter int unsigned COST_W = 8,
    parameter int unsigned TOT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic              in_dst_mem,
    input logic [1:0]        in_src_kind,
    input logic              in_src_acc,
    input logic              clear,
    input logic              res_valid,
    input logic [COST_W-1:0] res_cost,
    input logic              res_unsup,
    input logic [TOT_W-1:0]  total
);

    p_unsup_zero_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_unsup) |-> (res_cost == '0));

    p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    p_no_spurious_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    p_total_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> $stable(total));

    p_total_adds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear) |=> (total == $past(total) + TOT_W'(res_cost)));

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total == '0));

    p_acc_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd0 && in_dst_mem && in_src_kind == 2'd0 && in_src_acc)
        |=> (res_cost == COST_W'(10) && !res_unsup));

    p_min_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_unsup) |-> (res_cost >= COST_W'(2)));

endmodule

bind cce_top cce_checker #(
    .EA_W   (EA_W),
    .COST_W (COST_W),
    .TOT_W  (TOT_W)
) u_cce_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_dst_mem  (in_dst_mem),
    .in_src_kind (in_src_kind),
    .in_src_acc  (in_src_acc),
    .clear       (clear),
    .res_valid   (res_valid),
    .res_cost    (res_cost),
    .res_unsup   (res_unsup),
    .total       (total)
);

// File: tb/cce_top_bench.sv
module cce_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic        in_dst_mem = 1'b0;
    logic        in_dst_acc = 1'b0;
    logic [1:0]  in_src_kind = '0;
    logic        in_src_acc = 1'b0;
    logic [4:0]  in_ea_cost = '0;
    logic        clear = 1'b0;
    logic        res_valid;
    logic [7:0]  res_cost;
    logic        res_unsup;
    logic [31:0] total;

    int    n_vec = 0;
    int    n_err = 0;
    longint exp_total = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    cce_top u_cce_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_dst_mem  (in_dst_mem),
        .in_dst_acc  (in_dst_acc),
        .in_src_kind (in_src_kind),
        .in_src_acc  (in_src_acc),
        .in_ea_cost  (in_ea_cost),
        .clear       (clear),
        .res_valid   (res_valid),
        .res_cost    (res_cost),
        .res_unsup   (res_unsup),
        .total       (total)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference costs written from the requirement list.
    function automatic int ref_cost(input int op, input bit dm, input bit da,
                                    input int sk, input bit sa, input int ea,
                                    output bit unsup);
        unsup = 1'b0;
        if (op > 1 || sk == 3 || (dm && sk == 2)) begin
            unsup = 1'b1;
            return 0;
        end
        if (op == 0) begin
            if ((sk == 0 && sa && dm) || (sk == 2 && da && !dm)) return 10;
            if (!dm && sk == 0) return 2;
            if (!dm && sk == 1) return 4;
            if (!dm && sk == 2) return 8 + ea;
            if (dm && sk == 0)  return 9 + ea;
            return 10 + ea;
        end
        if (!dm && sk == 0) return 3;
        if (!dm && sk == 1) return 4;
        if (!dm && sk == 2) return 9 + ea;
        if (dm && sk == 0)  return 16 + ea;
        return 17 + ea;
    endfunction

    // Offer one instruction and check the result one edge later.
    task automatic apply(input string req, input int op, input bit dm, input bit da,
                         input int sk, input bit sa, input int ea, input bit clr);
        bit u;
        int c;
        c = ref_cost(op, dm, da, sk, sa, ea, u);
        @(negedge clk);
        in_valid    = 1'b1;
        in_op       = 2'(op);
        in_dst_mem  = dm;
        in_dst_acc  = da;
        in_src_kind = 2'(sk);
        in_src_acc  = sa;
        in_ea_cost  = 5'(ea);
        clear       = clr;
        @(negedge clk);
        in_valid = 1'b0;
        clear    = 1'b0;
        if (clr) exp_total = 0;
        else if (!u) exp_total = (exp_total + c) & 64'hFFFF_FFFF;
        chk({req, " valid"}, longint'(res_valid), 1);
        chk({req, " cost"}, longint'(res_cost), c);
        chk({req, " unsup"}, longint'(res_unsup), longint'(u));
        chk({req, " total"}, longint'(total), exp_total);
    endtask

    task automatic t_reset();
        chk("R10 valid", longint'(res_valid), 0);
        chk("R10 cost", longint'(res_cost), 0);
        chk("R10 unsup", longint'(res_unsup), 0);
        chk("R10 total", longint'(total), 0);
    endtask

    task automatic t_move();
        apply("R2 mov rr", 0, 0, 0, 0, 0, 7, 0);
        apply("R2 mov ir", 0, 0, 0, 1, 0, 7, 0);
        apply("R3 mov mr", 0, 0, 0, 2, 0, 5, 0);
        apply("R3 mov rm", 0, 1, 0, 0, 0, 6, 0);
        apply("R3 mov im", 0, 1, 0, 1, 0, 11, 0);
    endtask

    task automatic t_acc();
        apply("R1 acc to mem", 0, 1, 0, 0, 1, 9, 0);
        apply("R1 mem to acc", 0, 0, 1, 2, 0, 12, 0);
        apply("R1 acc flag on imm", 0, 1, 0, 1, 1, 4, 0);
    endtask

    task automatic t_add();
        apply("R4 add rr", 1, 0, 0, 0, 0, 3, 0);
        apply("R4 add imm acc", 1, 0, 1, 1, 0, 8, 0);
        apply("R4 add mem acc", 1, 0, 1, 2, 0, 7, 0);
        apply("R5 add mr", 1, 0, 0, 2, 0, 7, 0);
        apply("R5 add rm acc src", 1, 1, 0, 0, 1, 8, 0);
        apply("R5 add im", 1, 1, 0, 1, 0, 13, 0);
    endtask

    task automatic t_ea_ignored();
        apply("R11 mov rr ea max", 0, 0, 0, 0, 0, 31, 0);
        apply("R11 add ir ea max", 1, 0, 0, 1, 0, 31, 0);
        apply("R11 acc form ea max", 0, 0, 1, 2, 0, 31, 0);
        apply("R3 mov mr ea max", 0, 0, 0, 2, 0, 31, 0);
    endtask

    task automatic t_unsup();
        apply("R6 op 2", 2, 0, 0, 0, 0, 3, 0);
        apply("R6 op 3", 3, 1, 0, 1, 0, 3, 0);
        apply("R6 src 3", 0, 0, 0, 3, 0, 3, 0);
        apply("R6 mem mem", 1, 1, 0, 2, 0, 9, 0);
    endtask

    task automatic t_stream();
        // Back-to-back pair, then an idle cycle.
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd1; in_dst_mem = 1'b0; in_dst_acc = 1'b0;
        in_src_kind = 2'd0; in_src_acc = 1'b0; in_ea_cost = 5'd0;
        @(negedge clk);
        exp_total = exp_total + 3;
        chk("R7 stream first cost", longint'(res_cost), 3);
        in_op = 2'd0; in_dst_mem = 1'b1; in_src_kind = 2'd1; in_ea_cost = 5'd2;
        @(negedge clk);
        in_valid = 1'b0;
        exp_total = exp_total + 12;
        chk("R7 stream second valid", longint'(res_valid), 1);
        chk("R7 stream second cost", longint'(res_cost), 12);
        chk("R8 stream total", longint'(total), exp_total);
        @(negedge clk);
        chk("R7 idle valid low", longint'(res_valid), 0);
        chk("R8 idle total held", longint'(total), exp_total);
    endtask

    task automatic t_clear();
        apply("R9 clear with instr", 1, 1, 0, 1, 0, 5, 1);
        apply("R8 after clear", 0, 1, 0, 0, 0, 4, 0);
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_total = 0;
        chk("R9 clear alone", longint'(total), 0);
        chk("R7 clear gives no result", longint'(res_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_move();
        t_acc();
        t_add();
        t_ea_ignored();
        t_unsup();
        t_stream();
        t_clear();
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule